// File: doc/BRIEF.md
# Runtime-Polynomial Serial CRC Checker

This block verifies the cyclic redundancy check that closes a serial position-encoder frame. The receive path feeds it one bit at a time. A qualifying strobe marks each valid bit, a start pulse opens a frame, and an end marker separates the covered payload from the check bits. The payload is the position word followed by the status bits. The generator polynomial is not fixed in hardware. It is taken from an 8-bit mask input. Mask bit k is the coefficient of x^(k+1), and the constant term is always present, so one circuit serves every CRC from 4 to 8 bits.

The degree of the polynomial is found from the highest set mask bit. After the end marker the block takes in exactly that many check bits. On the line, the check bits arrive inverted and most significant first. When the last check bit arrives, the block raises a one-cycle done pulse and a result flag. The result flag stays put until the next frame starts. An all-zero mask means the frame has no check field. In that case the block completes at once with a pass and takes in no check bits. The mask must be held stable from the start pulse until done.

Top module: `crc_mask_checker`

## Requirements
- R1: The checker computes the remainder over the payload bits. The register starts at zero, bits enter most significant first, and the generator is x^L + sum of mask[k]·x^(k+1) for k < L-1, plus 1. With mask 0x21 the generator is x^6+x+1. With mask 0x09 it is x^4+x+1.
- R2: The CRC length L is the index of the highest set mask bit plus one. For example, 0x21 gives 6, 0x09 gives 4 and 0x83 gives 8. Exactly L valid bits after the end marker are taken as check bits.
- R3: Each received check bit is inverted before the compare. After done, `crc_err_o` is 0 when the inverted received bits equal the remainder and 1 when they do not.
- R4: With mask 0x00, `done_o` is 1 in the cycle after the end marker and `crc_err_o` is 0. Valid bits that follow are not consumed and give no further done.
- R5: `done_o` is a single-cycle pulse. It is high in the cycle after the clock edge that samples the last check bit.
- R6: `crc_err_o` holds its value from done until the next start pulse. A start pulse clears both `crc_err_o` and `done_o` in the following cycle.
- R7: A start pulse takes priority at any point, including mid-frame. A valid bit presented in the same cycle as the start pulse is discarded.
- R8: A valid bit presented in the same cycle as the end marker is the last payload bit and is covered by the CRC.
- R9: Valid bits and end markers outside an open frame, that is before the first start or after done, cause no done and leave `crc_err_o` unchanged.
- R10: After reset, `done_o` and `crc_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| poly_mask_i | input | 8 | Generator mask; bit k is the coefficient of x^(k+1) |
| frame_start_i | input | 1 | Start-of-frame clear pulse |
| bit_valid_i | input | 1 | Serial bit qualifier |
| bit_i | input | 1 | Serial data bit |
| payload_end_i | input | 1 | End of covered payload marker |
| done_o | output | 1 | One-cycle completion pulse |
| crc_err_o | output | 1 | Check result, 1 = mismatch, held until next start |

## Verification
Two pairs of functions can land in one cycle. The first pair is the last payload bit and the end marker. The bench sends both in one cycle and expects a pass, which can only happen if that bit was folded into the remainder. The second pair is a restart and a valid bit. The bench aborts a frame part-way by sending a start pulse with a 1 bit in the same cycle. It then completes a fresh frame whose expected remainder ignores that bit, so a wrongly absorbed bit shows up as a mismatch.

// File: rtl/crcm_pkg.sv
package crcm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DATA  = 2'd1,
    ST_CHECK = 2'd2,
    ST_DONE  = 2'd3
  } crcm_state_e;
endpackage

// File: rtl/crcm_len_decode.sv
module crcm_len_decode #(
  parameter int MASK_W = 8,
  localparam int LEN_W = $clog2(MASK_W + 1)
) (
  input  logic [MASK_W-1:0] mask_i,
  output logic [LEN_W-1:0]  len_o,
  output logic [MASK_W-1:0] len_mask_o,
  output logic [MASK_W-1:0] top_bit_o
);
  // degree = position of highest set coefficient bit, plus one
  function automatic logic [LEN_W-1:0] degree_of(input logic [MASK_W-1:0] m);
    logic [LEN_W-1:0] d;
    d = '0;
    for (int k = 0; k < MASK_W; k++) begin
      if (m[k]) d = LEN_W'(k + 1);
    end
    return d;
  endfunction

  assign len_o = degree_of(mask_i);

  genvar g;
  generate
    for (g = 0; g < MASK_W; g++) begin : g_lenmask
      assign len_mask_o[g] = (len_o > LEN_W'(g));
      assign top_bit_o[g]  = (len_o == LEN_W'(g + 1));
    end
  endgenerate
endmodule

// File: rtl/crcm_lfsr.sv
module crcm_lfsr #(
  parameter int MASK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic              bit_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [MASK_W-1:0] len_mask_i,
  input  logic [MASK_W-1:0] top_bit_i,
  output logic [MASK_W-1:0] crc_o
);
  // one serial step of polynomial division, generator low part = {mask, 1}
  function automatic logic [MASK_W-1:0] crc_step(
    input logic [MASK_W-1:0] crc,
    input logic              din,
    input logic [MASK_W-1:0] mask,
    input logic [MASK_W-1:0] lm,
    input logic [MASK_W-1:0] tb
  );
    logic             fb;
    logic [MASK_W:0]  t;
    fb = din ^ (|(crc & tb));
    t  = {crc, 1'b0} ^ (fb ? {mask, 1'b1} : '0);
    return t[MASK_W-1:0] & lm;
  endfunction

  logic [MASK_W-1:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '0;
    end else if (clr_i) begin
      crc_q <= '0;
    end else if (shift_i) begin
      crc_q <= crc_step(crc_q, bit_i, mask_i, len_mask_i, top_bit_i);
    end
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/crcm_rx_capture.sv
module crcm_rx_capture #(
  parameter int MASK_W = 8,
  localparam int LEN_W = $clog2(MASK_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic              bit_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [MASK_W-1:0] len_mask_i,
  output logic [MASK_W-1:0] rx_next_o,
  output logic              last_o
);
  // line carries the check field inverted; restore it while shifting in
  function automatic logic [MASK_W-1:0] rx_step(
    input logic [MASK_W-1:0] rx,
    input logic              din,
    input logic [MASK_W-1:0] lm
  );
    logic [MASK_W:0] t;
    t = {rx, ~din};
    return t[MASK_W-1:0] & lm;
  endfunction

  logic [MASK_W-1:0] rx_q;
  logic [LEN_W-1:0]  cnt_q;

  assign rx_next_o = rx_step(rx_q, bit_i, len_mask_i);
  assign last_o    = shift_i && ((cnt_q + LEN_W'(1)) == len_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      rx_q  <= '0;
      cnt_q <= '0;
    end else if (shift_i) begin
      rx_q  <= rx_next_o;
      cnt_q <= cnt_q + LEN_W'(1);
    end
  end
endmodule

// File: rtl/crc_mask_checker.sv
module crc_mask_checker
  import crcm_pkg::*;
#(
  parameter int MASK_W = 8,
  localparam int LEN_W = $clog2(MASK_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MASK_W-1:0] poly_mask_i,
  input  logic              frame_start_i,
  input  logic              bit_valid_i,
  input  logic              bit_i,
  input  logic              payload_end_i,
  output logic              done_o,
  output logic              crc_err_o
);
  crcm_state_e       state_q;
  logic              done_q;
  logic              err_q;

  logic [LEN_W-1:0]  crc_len;
  logic [MASK_W-1:0] len_mask;
  logic [MASK_W-1:0] top_bit;
  logic [MASK_W-1:0] crc_val;
  logic [MASK_W-1:0] rx_next;

  // named internal events
  logic frame_clr;
  logic data_shift;
  logic crc_shift;
  logic last_crc_bit;
  logic no_crc_field;
  logic crc_mismatch;

  assign frame_clr    = frame_start_i;
  assign data_shift   = !frame_start_i && (state_q == ST_DATA) && bit_valid_i;
  assign crc_shift    = !frame_start_i && (state_q == ST_CHECK) && bit_valid_i;
  assign no_crc_field = (crc_len == '0);
  assign crc_mismatch = (rx_next != crc_val);

  crcm_len_decode #(.MASK_W(MASK_W)) u_len (
    .mask_i     (poly_mask_i),
    .len_o      (crc_len),
    .len_mask_o (len_mask),
    .top_bit_o  (top_bit)
  );

  crcm_lfsr #(.MASK_W(MASK_W)) u_lfsr (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (frame_clr),
    .shift_i    (data_shift),
    .bit_i      (bit_i),
    .mask_i     (poly_mask_i),
    .len_mask_i (len_mask),
    .top_bit_i  (top_bit),
    .crc_o      (crc_val)
  );

  crcm_rx_capture #(.MASK_W(MASK_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (frame_clr),
    .shift_i    (crc_shift),
    .bit_i      (bit_i),
    .len_i      (crc_len),
    .len_mask_i (len_mask),
    .rx_next_o  (rx_next),
    .last_o     (last_crc_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else if (frame_clr) begin
      state_q <= ST_DATA;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_DATA: begin
          if (payload_end_i) begin
            if (no_crc_field) begin
              done_q  <= 1'b1;
              err_q   <= 1'b0;
              state_q <= ST_DONE;
            end else begin
              state_q <= ST_CHECK;
            end
          end
        end
        ST_CHECK: begin
          if (last_crc_bit) begin
            done_q  <= 1'b1;
            err_q   <= crc_mismatch;
            state_q <= ST_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  assign done_o    = done_q;
  assign crc_err_o = err_q;
endmodule

// File: rtl/crcm_checker.sv
module crcm_checker
  import crcm_pkg::*;
#(
  parameter int MASK_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MASK_W-1:0] poly_mask_i,
  input logic              frame_start_i,
  input logic              bit_valid_i,
  input logic              payload_end_i,
  input logic              done_o,
  input logic              crc_err_o,
  input crcm_state_e       state_q
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R5

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i |=> (!done_o && !crc_err_o)); // R6

  AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start_i && !done_o && !$past(frame_start_i)) |=> (crc_err_o == $past(crc_err_o) || done_o)); // R6

  AST_ZERO_MASK_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start_i && state_q == ST_DATA && payload_end_i && poly_mask_i == '0) |=> (done_o && !crc_err_o)); // R4

  AST_NO_DONE_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start_i && (state_q == ST_DONE || state_q == ST_IDLE)) |=> !done_o); // R9

  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start_i && bit_valid_i) |=> (state_q == ST_DATA)); // R7
endmodule

bind crc_mask_checker crcm_checker #(.MASK_W(MASK_W)) u_crcm_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .poly_mask_i   (poly_mask_i),
  .frame_start_i (frame_start_i),
  .bit_valid_i   (bit_valid_i),
  .payload_end_i (payload_end_i),
  .done_o        (done_o),
  .crc_err_o     (crc_err_o),
  .state_q       (state_q)
);

// File: tb/crc_mask_checker_tb.sv
module crc_mask_checker_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] poly_mask = 8'h21;
  logic       frame_start = 1'b0;
  logic       bit_valid = 1'b0;
  logic       bit_in = 1'b0;
  logic       payload_end = 1'b0;
  logic       done;
  logic       crc_err;

  int checks = 0;
  int failures = 0;
  int done_cnt = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc_mask_checker dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .poly_mask_i   (poly_mask),
    .frame_start_i (frame_start),
    .bit_valid_i   (bit_valid),
    .bit_i         (bit_in),
    .payload_end_i (payload_end),
    .done_o        (done),
    .crc_err_o     (crc_err)
  );

  always @(negedge clk) if (done) done_cnt++;

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ref_len(input logic [7:0] m);
    int l = 0;
    for (int k = 7; k >= 0; k--) if (m[k] && l == 0) l = k + 1;
    return l;
  endfunction

  // long division of message * x^L by the full generator
  function automatic logic [7:0] ref_crc(input logic [7:0] m, input logic [31:0] msg, input int n);
    int l = ref_len(m);
    logic [8:0] poly = {m, 1'b1};
    logic [8:0] rem = '0;
    for (int i = n - 1; i >= -l; i--) begin
      rem = {rem[7:0], (i >= 0) ? msg[i] : 1'b0};
      if (rem[l]) rem = rem ^ poly;
    end
    return rem[7:0];
  endfunction

  task automatic drive(input logic s, input logic v, input logic b, input logic e);
    @(negedge clk);
    frame_start = s; bit_valid = v; bit_in = b; payload_end = e;
  endtask

  task automatic run_frame(input logic [7:0] m, input logic [31:0] msg, input int n,
                           input logic [7:0] corrupt, input bit raw, input bit end_with_last,
                           input bit start_bit, input int exp_err, input string req);
    int l = ref_len(m);
    logic [7:0] c = ref_crc(m, msg, n);
    logic [7:0] tx = (raw ? c : ~c) ^ corrupt;
    int base;
    poly_mask = m;
    drive(1'b1, start_bit, 1'b1, 1'b0);
    base = done_cnt;
    for (int i = n - 1; i >= 0; i--) drive(1'b0, 1'b1, msg[i], end_with_last && i == 0);
    if (!end_with_last) drive(1'b0, 1'b0, 1'b0, 1'b1);
    for (int j = l - 1; j >= 0; j--) begin
      check(req, done, 0, "done before last check bit");
      drive(1'b0, 1'b1, tx[j], 1'b0);
    end
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    check("R5", done, 1, "done after last check bit");
    check(req, crc_err, exp_err, "crc_err at done");
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    check("R5", done, 0, "done second cycle");
    check("R2", done_cnt - base, 1, "done pulses in frame");
  endtask

  task automatic t_reset;
    check("R10", done, 0, "done after reset");
    check("R10", crc_err, 0, "crc_err after reset");
    drive(1'b0, 1'b1, 1'b1, 1'b1);
    drive(1'b0, 1'b1, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    check("R9", done_cnt, 0, "no done before first start");
  endtask

  task automatic t_zero_mask;
    int base;
    poly_mask = 8'h00;
    drive(1'b1, 1'b0, 1'b0, 1'b0);
    base = done_cnt;
    drive(1'b0, 1'b1, 1'b1, 1'b0);
    drive(1'b0, 1'b1, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b1);
    drive(1'b0, 1'b1, 1'b0, 1'b0);
    check("R4", done, 1, "zero mask done next cycle");
    check("R4", crc_err, 0, "zero mask passes");
    for (int i = 0; i < 6; i++) drive(1'b0, 1'b1, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    check("R4", done_cnt - base, 1, "no check bits consumed");
  endtask

  task automatic t_hold_and_ignore;
    int base;
    run_frame(8'h09, 32'h00000ABC, 12, 8'h01, 1'b0, 1'b0, 1'b0, 1, "R3");
    base = done_cnt;
    for (int i = 0; i < 10; i++) drive(1'b0, 1'b1, i[0], i == 3);
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    check("R6", crc_err, 1, "error held after done");
    check("R9", done_cnt - base, 0, "bits after done ignored");
    drive(1'b1, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    check("R6", crc_err, 0, "start clears error");
  endtask

  task automatic t_restart_mid_frame;
    poly_mask = 8'h21;
    drive(1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) drive(1'b0, 1'b1, 1'b1, 1'b0);
    run_frame(8'h21, 32'h0000005A, 8, 8'h00, 1'b0, 1'b0, 1'b1, 0, "R7");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_frame(8'h21, 32'h000A5F3C, 20, 8'h00, 1'b0, 1'b0, 1'b0, 0, "R1");
    run_frame(8'h21, 32'h000A5F3C, 20, 8'h04, 1'b0, 1'b0, 1'b0, 1, "R3");
    run_frame(8'h09, 32'h0000BEEF, 16, 8'h00, 1'b0, 1'b0, 1'b0, 0, "R1");
    run_frame(8'h83, 32'h12345678, 32, 8'h00, 1'b0, 1'b0, 1'b0, 0, "R2");
    run_frame(8'h83, 32'h12345678, 32, 8'h80, 1'b0, 1'b0, 1'b0, 1, "R2");
    run_frame(8'h21, 32'h00003C3C, 14, 8'h00, 1'b1, 1'b0, 1'b0, 1, "R3");
    run_frame(8'h21, 32'h0001F00F, 17, 8'h00, 1'b0, 1'b1, 1'b0, 0, "R8");
    run_frame(8'h09, 32'h00000001, 1, 8'h00, 1'b0, 1'b1, 1'b0, 0, "R8");
    t_zero_mask();
    t_hold_and_ignore();
    t_restart_mid_frame();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule